// File: doc/BRIEF.md
# DMA Channel Interrupt Status Unit

This block collects the interrupt events of an eight-channel DMA engine. Each channel can raise two kinds of event, transfer-complete (terminal count) and error. The block records each kind in its own bank of sticky raw bits. It gates each bank with a per-channel enable to form the masked status. It then merges the two masked banks into a per-channel combined status and a single interrupt line.

Software reads the banks through a 32-bit register port with address, write enable, write data and read data. It acknowledges a channel by writing a one to that channel's bit in one of two write-only clear registers, one per bank. When several channels are pending, the lowest-numbered channel has the highest priority. The index of that channel is driven on a dedicated output, so an interrupt handler can service the most urgent channel first without scanning the status.

Top module: `dma_irq_status`

## Requirements
- R1: After reset, every readable register returns 0, `irqOut` is low and `pendValid` is low.
- R2: A one-cycle pulse on `tcEvent[n]` sets bit n of the raw transfer-complete register (offset 0x014). The bit is readable from the next cycle and stays set until it is cleared.
- R3: A one-cycle pulse on `errEvent[n]` sets bit n of the raw error register (offset 0x018). The bit stays set until it is cleared.
- R4: The masked transfer-complete register (offset 0x004) reads raw transfer-complete AND `tcEnable`. The masked error register (offset 0x00C) reads raw error AND `errEnable`.
- R5: A write to offset 0x008 clears raw transfer-complete bit n for every data bit n that is 1. Data bits that are 0 leave their channels unchanged.
- R6: A write to offset 0x010 clears raw error bit n for every data bit n that is 1. Data bits that are 0 leave their channels unchanged.
- R7: When an event and a clear hit the same channel in the same cycle, the bit ends up set.
- R8: Bit n of the combined status register (offset 0x000) is 1 exactly when channel n has a masked transfer-complete or a masked error pending.
- R9: `irqOut` is high exactly when any bit of the combined status is 1.
- R10: `pendValid` equals `irqOut`. `pendIdx` holds the lowest channel number whose combined status bit is 1, and is 0 when none is pending.
- R11: Register bits 31:8 always read 0. Reads of the clear registers (0x008, 0x010) and of any unmapped address return 0.
- R12: Writes to read-only offsets or to unmapped addresses change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tcEvent | input | 8 | Per-channel transfer-complete event pulses |
| errEvent | input | 8 | Per-channel error event pulses |
| tcEnable | input | 8 | Per-channel transfer-complete interrupt enables |
| errEnable | input | 8 | Per-channel error interrupt enables |
| regAddr | input | 12 | Register byte address |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data for `regAddr`, combinational |
| irqOut | output | 1 | Combined interrupt request |
| pendValid | output | 1 | At least one channel is pending |
| pendIdx | output | 3 | Lowest-numbered pending channel |

## Verification
The hardest situation to reach is a clear and a new event landing on the same channel in the same edge. Random traffic seldom lines these up on a bit that is already set. Directed cycles therefore pulse every channel while writing all ones to each clear register. Priority resolution needs several channels pending at once under partial masks. To get there, the random phase keeps events dense enough for raw bits to pile up, and it flips the enables independently, so a masked-off low channel must not hide a higher one.

// File: rtl/dis_pkg.sv
package dis_pkg;
  localparam int RegW = 32;

  localparam int OfsComb   = 'h000;
  localparam int OfsTcMask = 'h004;
  localparam int OfsTcClr  = 'h008;
  localparam int OfsErMask = 'h00C;
  localparam int OfsErClr  = 'h010;
  localparam int OfsTcRaw  = 'h014;
  localparam int OfsErRaw  = 'h018;

  typedef enum logic [2:0] {
    SelNone, SelComb, SelTcMask, SelErMask, SelTcRaw, SelErRaw
  } rdSel_e;

  typedef struct packed {
    logic   clrTc;
    logic   clrErr;
    rdSel_e rdSel;
  } ctrlStrb_t;
endpackage

// File: rtl/dis_ctrl.sv
module dis_ctrl
  import dis_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  output ctrlStrb_t         strb
);
  always_comb begin
    strb = '{clrTc: 1'b0, clrErr: 1'b0, rdSel: SelNone};
    case (regAddr)
      ADDR_W'(OfsComb):   strb.rdSel  = SelComb;
      ADDR_W'(OfsTcMask): strb.rdSel  = SelTcMask;
      ADDR_W'(OfsErMask): strb.rdSel  = SelErMask;
      ADDR_W'(OfsTcRaw):  strb.rdSel  = SelTcRaw;
      ADDR_W'(OfsErRaw):  strb.rdSel  = SelErRaw;
      ADDR_W'(OfsTcClr):  strb.clrTc  = regWrEn;
      ADDR_W'(OfsErClr):  strb.clrErr = regWrEn;
      default:            strb.rdSel  = SelNone;
    endcase
  end
endmodule

// File: rtl/dis_dpath.sv
module dis_dpath
  import dis_pkg::*;
#(
  parameter int NCH = 8,
  parameter int IDX_W = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [NCH-1:0]   tcEvent,
  input  logic [NCH-1:0]   errEvent,
  input  logic [NCH-1:0]   tcEnable,
  input  logic [NCH-1:0]   errEnable,
  input  logic [RegW-1:0]  regWrData,
  input  ctrlStrb_t        strb,
  output logic [NCH-1:0]   rawTc,
  output logic [NCH-1:0]   rawErr,
  output logic [RegW-1:0]  regRdData,
  output logic             irqOut,
  output logic             pendValid,
  output logic [IDX_W-1:0] pendIdx
);
  logic [NCH-1:0] clrTcMask, clrErrMask;
  logic [NCH-1:0] maskTc, maskErr, comb;

  assign clrTcMask  = regWrData[NCH-1:0] & {NCH{strb.clrTc}};
  assign clrErrMask = regWrData[NCH-1:0] & {NCH{strb.clrErr}};

  // one sticky bit pair per channel; a new event outranks a clear
  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    always_ff @(posedge clk) begin
      if (!rstN) begin
        rawTc[ch]  <= 1'b0;
        rawErr[ch] <= 1'b0;
      end else begin
        if (tcEvent[ch])         rawTc[ch] <= 1'b1;
        else if (clrTcMask[ch])  rawTc[ch] <= 1'b0;
        if (errEvent[ch])        rawErr[ch] <= 1'b1;
        else if (clrErrMask[ch]) rawErr[ch] <= 1'b0;
      end
    end
  end

  assign maskTc  = rawTc & tcEnable;
  assign maskErr = rawErr & errEnable;
  assign comb    = maskTc | maskErr;
  assign irqOut  = |comb;
  assign pendValid = irqOut;

  always_comb begin
    pendIdx = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (comb[i]) pendIdx = IDX_W'(i);
    end
  end

  always_comb begin
    case (strb.rdSel)
      SelComb:   regRdData = RegW'(comb);
      SelTcMask: regRdData = RegW'(maskTc);
      SelErMask: regRdData = RegW'(maskErr);
      SelTcRaw:  regRdData = RegW'(rawTc);
      SelErRaw:  regRdData = RegW'(rawErr);
      default:   regRdData = '0;
    endcase
  end
endmodule

// File: rtl/dma_irq_status.sv
module dma_irq_status
  import dis_pkg::*;
#(
  parameter int NCH = 8,
  parameter int ADDR_W = 12,
  localparam int IDX_W = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [NCH-1:0]   tcEvent,
  input  logic [NCH-1:0]   errEvent,
  input  logic [NCH-1:0]   tcEnable,
  input  logic [NCH-1:0]   errEnable,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic             regWrEn,
  input  logic [RegW-1:0]  regWrData,
  output logic [RegW-1:0]  regRdData,
  output logic             irqOut,
  output logic             pendValid,
  output logic [IDX_W-1:0] pendIdx
);
  ctrlStrb_t      strb;
  logic [NCH-1:0] rawTc, rawErr;

  dis_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .regAddr(regAddr), .regWrEn(regWrEn), .strb(strb)
  );

  dis_dpath #(.NCH(NCH), .IDX_W(IDX_W)) u_dpath (
    .clk(clk), .rstN(rstN),
    .tcEvent(tcEvent), .errEvent(errEvent),
    .tcEnable(tcEnable), .errEnable(errEnable),
    .regWrData(regWrData), .strb(strb),
    .rawTc(rawTc), .rawErr(rawErr),
    .regRdData(regRdData), .irqOut(irqOut),
    .pendValid(pendValid), .pendIdx(pendIdx)
  );
endmodule

// File: rtl/dma_irq_status_chk.sv
module dma_irq_status_chk #(
  parameter int NCH = 8,
  parameter int ADDR_W = 12,
  parameter int IDX_W = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic [NCH-1:0]    tcEvent,
  input logic [NCH-1:0]    errEvent,
  input logic [NCH-1:0]    tcEnable,
  input logic [NCH-1:0]    errEnable,
  input logic [ADDR_W-1:0] regAddr,
  input logic              regWrEn,
  input logic [NCH-1:0]    rawTc,
  input logic [NCH-1:0]    rawErr,
  input logic              irqOut,
  input logic              pendValid,
  input logic [IDX_W-1:0]  pendIdx
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rstN |=> (rawTc == '0 && rawErr == '0));

  // R2 R7
  tc_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|tcEvent) |=> ((rawTc & $past(tcEvent)) == $past(tcEvent)));

  // R3 R7
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|errEvent) |=> ((rawErr & $past(errEvent)) == $past(errEvent)));

  // R5 R12
  tc_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!(regWrEn && regAddr == ADDR_W'('h008)) && tcEvent == '0) |=> $stable(rawTc));

  // R6 R12
  err_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!(regWrEn && regAddr == ADDR_W'('h010)) && errEvent == '0) |=> $stable(rawErr));

  // R9
  irq_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqOut == (((rawTc & tcEnable) | (rawErr & errEnable)) != '0));

  // R10
  pend_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    pendValid == irqOut);

  // R10
  pend_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !pendValid |-> pendIdx == '0);
endmodule

bind dma_irq_status dma_irq_status_chk #(.NCH(NCH), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rstN(rstN), .tcEvent(tcEvent), .errEvent(errEvent),
  .tcEnable(tcEnable), .errEnable(errEnable), .regAddr(regAddr),
  .regWrEn(regWrEn), .rawTc(rawTc), .rawErr(rawErr), .irqOut(irqOut),
  .pendValid(pendValid), .pendIdx(pendIdx)
);

// File: tb/tb_dma_irq_status.sv
module tb_dma_irq_status;
  logic        clk = 1'b0;
  logic        rstN;
  logic [7:0]  tcEvent, errEvent, tcEnable, errEnable;
  logic [11:0] regAddr;
  logic        regWrEn;
  logic [31:0] regWrData, regRdData;
  logic        irqOut, pendValid;
  logic [2:0]  pendIdx;

  int checks = 0;
  int fails  = 0;
  logic [7:0] mTc = '0, mErr = '0;

  always #4 clk = ~clk;

  dma_irq_status dut (
    .clk(clk), .rstN(rstN), .tcEvent(tcEvent), .errEvent(errEvent),
    .tcEnable(tcEnable), .errEnable(errEnable), .regAddr(regAddr),
    .regWrEn(regWrEn), .regWrData(regWrData), .regRdData(regRdData),
    .irqOut(irqOut), .pendValid(pendValid), .pendIdx(pendIdx)
  );

  function automatic logic [31:0] expRd(input logic [11:0] a);
    logic [7:0] t = mTc & tcEnable;
    logic [7:0] e = mErr & errEnable;
    case (a)
      12'h000: return {24'h0, t | e};
      12'h004: return {24'h0, t};
      12'h00C: return {24'h0, e};
      12'h014: return {24'h0, mTc};
      12'h018: return {24'h0, mErr};
      default: return 32'h0;
    endcase
  endfunction

  function automatic string rdTag(input logic [11:0] a);
    case (a)
      12'h000: return "R8";
      12'h004, 12'h00C: return "R4";
      12'h014: return "R2";
      12'h018: return "R3";
      default: return "R11";
    endcase
  endfunction

  function automatic logic [2:0] lowest(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) if (v[i]) lowest = 3'(i);
    if (v == 0) lowest = 3'd0;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic [7:0] tev, input logic [7:0] eev,
                     input logic [7:0] ten, input logic [7:0] een,
                     input logic [11:0] a, input logic we, input logic [31:0] wd,
                     input string tag);
    logic [7:0] comb, clrT, clrE;
    @(negedge clk);
    tcEvent = tev; errEvent = eev; tcEnable = ten; errEnable = een;
    regAddr = a; regWrEn = we; regWrData = wd;
    #1;
    chk(tag == "" ? rdTag(a) : tag, regRdData, expRd(a));
    comb = (mTc & ten) | (mErr & een);
    chk("R9", {31'h0, irqOut}, {31'h0, comb != 0});
    chk("R10", {28'h0, pendValid, pendIdx}, {28'h0, comb != 0, lowest(comb)});
    @(posedge clk);
    clrT = (we && a == 12'h008) ? wd[7:0] : 8'h0;
    clrE = (we && a == 12'h010) ? wd[7:0] : 8'h0;
    mTc  = (mTc & ~clrT) | tev;
    mErr = (mErr & ~clrE) | eev;
  endtask

  initial begin
    #(200000 * 8);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [11:0] addrs [10] = '{12'h000, 12'h004, 12'h008, 12'h00C, 12'h010,
                                12'h014, 12'h018, 12'h01C, 12'h100, 12'h006};
    void'($urandom(32'h5eed_1234));
    rstN = 1'b0;
    tcEvent = '0; errEvent = '0; tcEnable = '0; errEnable = '0;
    regAddr = '0; regWrEn = 1'b0; regWrData = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;

    // R1: every register reads zero after reset, even with all enables on
    foreach (addrs[i]) cyc(8'h0, 8'h0, 8'hFF, 8'hFF, addrs[i], 1'b0, 32'h0, "R1");

    // R2 R3: set sparse bits, then read raw banks
    cyc(8'h81, 8'h24, 8'hFF, 8'hFF, 12'h014, 1'b0, 32'h0, "R2");
    cyc(8'h00, 8'h00, 8'hFF, 8'hFF, 12'h014, 1'b0, 32'h0, "R2");
    cyc(8'h00, 8'h00, 8'hFF, 8'hFF, 12'h018, 1'b0, 32'h0, "R3");
    // R4: partial masks
    cyc(8'h00, 8'h00, 8'h01, 8'h04, 12'h004, 1'b0, 32'h0, "R4");
    cyc(8'h00, 8'h00, 8'h01, 8'h04, 12'h00C, 1'b0, 32'h0, "R4");
    // R10: low channel masked off, higher one must be reported
    cyc(8'h00, 8'h00, 8'h80, 8'h20, 12'h000, 1'b0, 32'h0, "R8");
    // R5: zero write leaves state; R12: write to read-only and unmapped
    cyc(8'h00, 8'h00, 8'hFF, 8'hFF, 12'h008, 1'b1, 32'h0, "R11");
    cyc(8'h00, 8'h00, 8'hFF, 8'hFF, 12'h014, 1'b1, 32'hFFFF_FFFF, "R5");
    cyc(8'h00, 8'h00, 8'hFF, 8'hFF, 12'h024, 1'b1, 32'hFFFF_FFFF, "R12");
    cyc(8'h00, 8'h00, 8'hFF, 8'hFF, 12'h014, 1'b0, 32'h0, "R12");
    // R5 R6: partial clears
    cyc(8'h00, 8'h00, 8'hFF, 8'hFF, 12'h008, 1'b1, 32'hFFFF_FF01, "R11");
    cyc(8'h00, 8'h00, 8'hFF, 8'hFF, 12'h010, 1'b1, 32'h0000_0004, "R11");
    cyc(8'h00, 8'h00, 8'hFF, 8'hFF, 12'h014, 1'b0, 32'h0, "R5");
    cyc(8'h00, 8'h00, 8'hFF, 8'hFF, 12'h018, 1'b0, 32'h0, "R6");
    // R7: event and clear on every channel in the same cycle
    cyc(8'hFF, 8'h00, 8'hFF, 8'hFF, 12'h008, 1'b1, 32'hFF, "R11");
    cyc(8'h00, 8'hFF, 8'hFF, 8'hFF, 12'h010, 1'b1, 32'hFF, "R7");
    cyc(8'h00, 8'h00, 8'hFF, 8'hFF, 12'h014, 1'b0, 32'h0, "R7");
    cyc(8'h00, 8'h00, 8'hFF, 8'hFF, 12'h018, 1'b0, 32'h0, "R7");

    // random phase
    for (int n = 0; n < 4000; n++) begin
      logic [7:0] tev = 8'($urandom) & 8'($urandom) & 8'($urandom);
      logic [7:0] eev = 8'($urandom) & 8'($urandom) & 8'($urandom);
      logic [11:0] a = addrs[$urandom % 10];
      logic we = ($urandom % 3) == 0;
      cyc(tev, eev, 8'($urandom), 8'($urandom), a, we, $urandom, "");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule